// File: doc/BRIEF.md
# XOR Interleave Address Translator

This block converts a 64-bit address between system physical and device host physical form for a root decoder that spreads traffic across host bridges with XOR arithmetic. A small bank of programmable 64-bit XOR masks is set up through a write port, together with a count of how many masks are configured. Each mask picks one target bit, the lowest bit set in the mask. That bit is replaced by the parity of the address ANDed with the mask. The masks are applied one after another, and each one sees the address as already changed by the masks before it.

The host-bridge way count of a request sets how many masks must be configured. If too few are configured, or the way count is not supported, the block returns an all-ones address and raises an error flag. Way counts of one and three bypass the masks. Each mask update is an XOR of its target bit with the parity of the mask's other bits. For this reason the same hardware serves both directions of the translation when the masks' target bits do not overlap.

Requests use a valid/ready pair. The registered result appears one cycle after acceptance, and it is held while the consumer stalls.

Top module: `xor_ilv_xlate`

## Requirements
- R1: The supported way counts on `in_ways` are 1, 2, 3, 4, 6, 8, 12 and 16. Any other value, including 0, gives an error result.
- R2: The number of masks a way count needs is 0 for 1 and 3, 1 for 2 and 6, 2 for 4 and 12, 3 for 8, and 4 for 16. A request whose need is larger than the configured mask count gives an error result.
- R3: An error result has `out_err` = 1 and `out_addr` = 64'hFFFF_FFFF_FFFF_FFFF. A good result has `out_err` = 0.
- R4: A mask forces the bit at the position of its lowest set bit to the parity of (current address AND mask). An odd population count gives 1 and an even count gives 0.
- R5: Masks 0, 1, 2 and 3 are applied in index order, each to the output of the previous one. Every mask whose index is below the configured count is applied, not only as many as the way count needs.
- R6: A mask register equal to zero changes no bit.
- R7: For way counts 1 and 3, `out_addr` equals `in_addr` and `out_err` is 0, whatever the masks and the count hold.
- R8: When no mask's lowest set bit appears in any other mask, translating the output a second time with the same masks and way count returns the original address.
- R9: A write with `cfg_addr` 0 to 3 loads that mask register from `cfg_wdata`. A write with `cfg_addr` 4 loads the mask count, and a value above 4 is stored as 4. Writes to addresses 5 to 7 change nothing. Reset clears all masks and sets the count to 0.
- R10: A request is accepted when `in_valid` and `in_ready` are both high. `out_valid` rises in the next cycle. `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select (0-3 masks, 4 count) |
| cfg_wdata | input | 64 | Configuration write data |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | 64 | Address to translate |
| in_ways | input | 5 | Host-bridge interleave way count |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Translated address or all ones |
| out_err | output | 1 | Result is an error |

## Verification
The assertions check on every cycle that an error result is all ones, that an accepted request always produces a result one cycle later, that a stalled result stays frozen, and that a bypass way count returns its input address unchanged. They also check that the stored mask count never exceeds the bank size. Only the bench scenarios can show that the parity and bit-position arithmetic is right. The same is true of the mask order, the skipping of zero masks, the need table against the configured count, the clamping of count writes and the round-trip identity. The bench compares fixed vectors and random masks against an independent model.

// File: rtl/xilx_pkg.sv
package xilx_pkg;
  localparam int ADDR_W = 64;
  localparam int NMAPS  = 4;
  localparam int WAY_W  = 5;
  localparam int CNT_W  = $clog2(NMAPS + 1);
  localparam int CFG_AW = $clog2(NMAPS + 1);

  typedef struct packed {
    logic             ok;
    logic             bypass;
    logic [CNT_W-1:0] need;
  } way_info_t;
endpackage

// File: rtl/xilx_map_bank.sv
module xilx_map_bank
  import xilx_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NM = NMAPS,
  parameter int CW = CNT_W,
  parameter int SW = CFG_AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SW-1:0]        sel,
  input  logic [AW-1:0]        wdata,
  output logic [NM-1:0][AW-1:0] maps,
  output logic [CW-1:0]        cnt
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  logic [NM-1:0][AW-1:0] map_q;
  logic [CW-1:0]         cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
      cnt_q <= '0;
    end else if (we) begin
      if (32'(sel) < NM) begin
        map_q[sel[IW-1:0]] <= wdata;
      end else if (32'(sel) == NM) begin
        if (wdata > AW'(NM)) cnt_q <= CW'(NM);
        else                 cnt_q <= wdata[CW-1:0];
      end
    end
  end

  assign maps = map_q;
  assign cnt  = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) <= NM); // R9
endmodule

// File: rtl/xilx_way_decode.sv
module xilx_way_decode
  import xilx_pkg::*;
(
  input  logic [WAY_W-1:0] ways,
  output way_info_t        info
);
  always_comb begin
    info = '{ok: 1'b1, bypass: 1'b0, need: '0};
    case (ways)
      5'd1:  info.bypass = 1'b1;
      5'd3:  info.bypass = 1'b1;
      5'd2:  info.need = CNT_W'(1);
      5'd6:  info.need = CNT_W'(1);
      5'd4:  info.need = CNT_W'(2);
      5'd12: info.need = CNT_W'(2);
      5'd8:  info.need = CNT_W'(3);
      5'd16: info.need = CNT_W'(4);
      default: info.ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/xilx_xor_stage.sv
module xilx_xor_stage #(
  parameter int AW = 64
) (
  input  logic          en,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] a_in,
  output logic [AW-1:0] a_out
);
  logic [AW-1:0] low_oh;
  logic          par;

  assign low_oh = mask & (~mask + AW'(1));
  assign par    = ^(a_in & mask);

  always_comb begin
    if (en) a_out = (a_in & ~low_oh) | (par ? low_oh : '0);
    else    a_out = a_in;
  end
endmodule

// File: rtl/xor_ilv_xlate.sv
module xor_ilv_xlate
  import xilx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [WAY_W-1:0]  in_ways,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err
);
  logic [NMAPS-1:0][ADDR_W-1:0] maps;
  logic [CNT_W-1:0]             map_cnt;
  way_info_t                    winfo;
  logic [ADDR_W-1:0]            chain [NMAPS+1];
  logic                         err_c;
  logic [ADDR_W-1:0]            res_c;
  logic                         accept;

  xilx_map_bank u_bank (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_addr), .wdata(cfg_wdata),
    .maps(maps), .cnt(map_cnt)
  );

  xilx_way_decode u_wdec (.ways(in_ways), .info(winfo));

  assign chain[0] = in_addr;
  for (genvar i = 0; i < NMAPS; i++) begin : g_stage
    xilx_xor_stage #(.AW(ADDR_W)) u_stage (
      .en(map_cnt > CNT_W'(i)),
      .mask(maps[i]),
      .a_in(chain[i]),
      .a_out(chain[i+1])
    );
  end

  assign err_c  = !winfo.ok || (winfo.need > map_cnt);
  assign res_c  = err_c ? '1 : (winfo.bypass ? in_addr : chain[NMAPS]);
  assign in_ready = !out_valid || out_ready;
  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_err   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_addr  <= res_c;
      out_err   <= err_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ERR_ALLONES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_addr == '1)); // R3
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_err))); // R10
  AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_ways == 5'd1 || in_ways == 5'd3))
      |=> (out_addr == $past(in_addr) && !out_err)); // R7
endmodule

// File: tb/xor_ilv_xlate_tb.sv
module xor_ilv_xlate_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [63:0] cfg_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_addr;
  logic [4:0]  in_ways;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_addr;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  logic [63:0] bm [4];
  int          bcnt;

  always #5 clk = ~clk;

  xor_ilv_xlate u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_ways(in_ways), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_err(out_err)
  );

  // {ways, addr, expected addr, expected err} with masks 0x1100,0x2200,0x4400,0x8800, count 4
  localparam logic [133:0] VEC [0:10] = '{
    {5'd2,  64'h0000_0000_0000_1000, 64'h0000_0000_0000_1100, 1'b0},
    {5'd4,  64'h0000_0000_0000_F000, 64'h0000_0000_0000_FF00, 1'b0},
    {5'd16, 64'hDEAD_0000_0000_A5A5, 64'hDEAD_0000_0000_AFA5, 1'b0},
    {5'd1,  64'h0000_0000_0000_1000, 64'h0000_0000_0000_1000, 1'b0},
    {5'd3,  64'h0000_0000_0000_F000, 64'h0000_0000_0000_F000, 1'b0},
    {5'd5,  64'h0000_0000_0000_1234, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    {5'd0,  64'h0000_0000_0000_1234, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    {5'd12, 64'h0300_0000_0000_3300, 64'h0300_0000_0000_3000, 1'b0},
    {5'd8,  64'h0000_0000_0000_0F00, 64'h0000_0000_0000_0F00, 1'b0},
    {5'd6,  64'h0000_0000_0000_5000, 64'h0000_0000_0000_5500, 1'b0},
    {5'd17, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a < 3'd4) bm[a[1:0]] = d;
    else if (a == 3'd4) bcnt = (d > 64'd4) ? 4 : int'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xlate(input logic [4:0] w, input logic [63:0] a,
                       output logic [63:0] r, output logic e);
    @(negedge clk);
    in_valid = 1'b1; in_ways = w; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    r = out_addr; e = out_err;
    if (!out_valid) begin
      checks++; errors++;
      $display("FAIL R10: actual out_valid 0 expected 1");
    end
  endtask

  function automatic logic [64:0] model(input logic [4:0] w, input logic [63:0] a);
    int need;
    logic [63:0] x;
    need = -1;
    case (w)
      5'd1, 5'd3: need = 0;
      5'd2, 5'd6: need = 1;
      5'd4, 5'd12: need = 2;
      5'd8: need = 3;
      5'd16: need = 4;
      default: need = -1;
    endcase
    if (need < 0 || need > bcnt) return {1'b1, 64'hFFFF_FFFF_FFFF_FFFF};
    if (w == 5'd1 || w == 5'd3) return {1'b0, a};
    x = a;
    for (int i = 0; i < bcnt; i++) begin
      if (bm[i] != 64'd0) begin
        int pos;
        int ones;
        pos = 0;
        for (int b = 63; b >= 0; b--) if (bm[i][b]) pos = b;
        ones = 0;
        for (int b = 0; b < 64; b++) if (x[b] && bm[i][b]) ones++;
        x[pos] = ones[0];
      end
    end
    return {1'b0, x};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [63:0] r, r2;
    logic e, e2;
    logic [4:0] wl [8] = '{5'd1, 5'd2, 5'd3, 5'd4, 5'd6, 5'd8, 5'd12, 5'd16};
    for (int i = 0; i < 4; i++) bm[i] = 64'd0;
    bcnt = 0;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_addr = '0; in_ways = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset out_valid", {64'd0, out_valid}, 65'd0);
    chk("R10 reset in_ready", {64'd0, in_ready}, 65'd1);
    // R9 reset: count 0 -> ways 2 errors, ways 1 passes
    xlate(5'd2, 64'h1000, r, e);
    chk("R9 reset count zero", {e, r}, {1'b1, 64'hFFFF_FFFF_FFFF_FFFF});
    xlate(5'd1, 64'h1234, r, e);
    chk("R7 bypass count zero", {e, r}, {1'b0, 64'h1234});

    cfg_write(3'd0, 64'h1100);
    cfg_write(3'd1, 64'h2200);
    cfg_write(3'd2, 64'h4400);
    cfg_write(3'd3, 64'h8800);
    cfg_write(3'd4, 64'd4);
    for (int k = 0; k < 11; k++) begin
      xlate(VEC[k][133:129], VEC[k][128:65], r, e);
      chk("R1 R2 R3 R4 R5 R7 vector", {e, r}, {VEC[k][0], VEC[k][64:1]});
    end

    // R2: count 1 is too few for ways 4 but enough for 2 and 6; R5 only mask 0 applied
    cfg_write(3'd4, 64'd1);
    xlate(5'd4, 64'hF000, r, e);
    chk("R2 need exceeds count", {e, r}, {1'b1, 64'hFFFF_FFFF_FFFF_FFFF});
    xlate(5'd2, 64'hF000, r, e);
    chk("R5 only configured masks", {e, r}, {1'b0, 64'hF100});
    xlate(5'd6, 64'hF000, r, e);
    chk("R5 ways 6 count 1", {e, r}, {1'b0, 64'hF100});
    // R5: all configured masks applied even when fewer needed
    cfg_write(3'd4, 64'd3);
    xlate(5'd2, 64'hF000, r, e);
    chk("R5 all configured applied", {e, r}, {1'b0, 64'hF700});
    // R9 clamp and ignored addresses
    cfg_write(3'd4, 64'd7);
    cfg_write(3'd5, 64'd0);
    cfg_write(3'd7, 64'd0);
    xlate(5'd16, 64'hF000, r, e);
    chk("R9 clamp count to 4", {e, r}, {1'b0, 64'hFF00});
    // R6 zero mask skipped
    cfg_write(3'd1, 64'd0);
    xlate(5'd16, 64'hF000, r, e);
    chk("R6 zero mask skipped", {e, r}, {1'b0, 64'hFD00});
    // R4 sequential chain: mask1 reads bit 8 set by mask0
    cfg_write(3'd1, 64'h0000_0000_0000_0300);
    xlate(5'd16, 64'h1000, r, e);
    chk("R4 chained parity", {e, r}, {1'b0, 64'h1100});

    // R10 stall hold
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_ways = 5'd7; in_addr = 64'h55;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 in_ready low while stalled", {64'd0, in_ready}, 65'd0);
    @(negedge clk);
    chk("R10 held result", {out_err, out_addr}, {1'b1, 64'hFFFF_FFFF_FFFF_FFFF});
    chk("R10 held valid", {64'd0, out_valid}, 65'd1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 drained", {64'd0, out_valid}, 65'd0);

    // random masks against model
    for (int n = 0; n < 300; n++) begin
      logic [63:0] a;
      logic [4:0] w;
      if (n % 10 == 0) begin
        for (int i = 0; i < 4; i++)
          cfg_write(3'(i), ($urandom % 5 == 0) ? 64'd0 : {$urandom, $urandom});
        cfg_write(3'd4, 64'($urandom % 6));
      end
      a = {$urandom, $urandom};
      w = ($urandom % 8 == 0) ? 5'($urandom) : wl[$urandom % 8];
      xlate(w, a, r, e);
      chk("R4 R5 R6 random model", {e, r}, model(w, a));
    end

    // R8 round trip with non-overlapping target bits
    for (int n = 0; n < 40; n++) begin
      logic [63:0] a;
      logic [4:0] w;
      for (int i = 0; i < 4; i++)
        cfg_write(3'(i), (64'd1 << (8 + i)) | ({$urandom, $urandom} & ~64'hFFFF));
      cfg_write(3'd4, 64'd4);
      a = {$urandom, $urandom};
      w = wl[$urandom % 8];
      xlate(w, a, r, e);
      xlate(w, r, r2, e2);
      chk("R8 round trip", {e2, r2}, {1'b0, a});
    end

    finish_run();
  end
endmodule